// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a single-port synchronous SRAM whose bus never idles when it switches between reads and writes. Address and control are captured on one rising edge. The data transfer for that access happens exactly two active edges later. For a write, the data is taken from `wdata` on that edge. For a read, the word is registered onto `rdata` on that edge. One access can start on every cycle, whatever the mix of reads and writes.

A single `rw` input selects read or write. Active-low lane enables mask each byte lane of a write. The load/advance input either starts a new access or steps a 4-beat burst in linear or interleaved order. An active-low clock enable freezes every register, including the array. Three chip selects decide whether a load starts an access or a deselect. `oe_n` is the only control that acts without the clock: it gates the read drive at once.

The data bus is split into `wdata` and `rdata`. `rdata_drive` stands for the output buffer, and its low level means high impedance. The bus timing is fixed by the pipeline and has no back-pressure, so it has no valid/ready handshake.

Top module: `zbt_sram`

## Requirements
- R1: A read sampled at active edge k (`rw`=1) puts the addressed word on `rdata` after active edge k+2, with `rdata_drive` high while `oe_n` is low. After the data phase of a write or a deselect, `rdata_drive` is low.
- R2: A write sampled at active edge k takes `wdata` at active edge k+2. It updates only the lanes whose `lane_we_n` bit was low at edge k. Lane i is bits [9i+8:9i] at the default sizes. Lanes with their bit high keep their old contents.
- R3: Reads and writes may be issued on consecutive cycles in any mix with no idle cycle between them. A read issued one cycle after a write to the same address returns the new data.
- R4: With `adv_ld`=1, the access continues the current burst. The upper address bits stay those of the loading access, and the operation type is the one from the loading cycle (`rw` is ignored). Beat n (n=1..3, then wrapping) has low two bits equal to start+n mod 4 in linear order, or start XOR n in interleaved order.
- R5: `burst_lin`, sampled at the load cycle, selects the order for the whole burst: 1 = linear, 0 = interleaved.
- R6: While `clk_en_n` is high, all synchronous inputs are ignored and every register holds, including `rdata`, `rdata_drive` and the array. Pending accesses complete later by the number of stalled cycles.
- R7: A load (`adv_ld`=0) with `sel_a_n` high, `sel_b` low or `sel_c_n` high starts no access. `rdata_drive` is low after the second following active edge, and `wdata` at that edge does not reach the array. Advances after a deselect stay deselected.
- R8: `oe_n` high forces `rdata_drive` low at once, without a clock edge, and does not disturb the pipeline.
- R9: After reset, `rdata_drive` is low, `rdata` is zero and no access is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| clk_en_n | input | 1 | Active-low clock enable; high stalls every register |
| adv_ld | input | 1 | 0 = load a new access, 1 = advance the burst |
| rw | input | 1 | 1 = read, 0 = write (sampled on load) |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| burst_lin | input | 1 | Burst order on load: 1 = linear, 0 = interleaved |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| addr | input | AW | Word address |
| wdata | input | DW | Write data, taken two active edges after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | DW | Registered read data |
| rdata_drive | output | 1 | High when `rdata` is driven; low means high impedance |

## Verification
A fault in the burst state shows on the third beat of a burst: `rdata` returns the word of a neighbouring address, two active edges after that beat was issued. A fault in the stage registers or the stall hold shows as a word that is late, early, or doubled by one cycle, or as `rdata_drive` high in a write's data phase. The reference memory shows these at the first read that follows. A mask or deselect fault corrupts stored lanes, and the next read of that address exposes it.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  localparam int BEAT_W = 2;

  // Low address bits of burst beat n, for a burst that started at 'start'.
  function automatic logic [BEAT_W-1:0] beat_low(input logic [BEAT_W-1:0] start,
                                                  input logic [BEAT_W-1:0] n,
                                                  input logic              lin);
    logic [BEAT_W-1:0] sum;
    sum = start + n;
    return lin ? sum : (start ^ n);
  endfunction
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             adv_ld,
  input  logic             rw,
  input  logic             sel_ok,
  input  logic             burst_lin,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_en,
  output logic             op_valid,
  output logic             op_rd,
  output logic [AW-1:0]    op_addr,
  output logic [LANES-1:0] op_lanes
);
  // Burst context kept from the last load
  logic              b_act, b_rd, b_lin;
  logic [AW-1:0]     b_base;
  logic [BEAT_W-1:0] b_cnt;

  logic              n_act, n_rd, n_lin;
  logic [AW-1:0]     n_base, n_addr;
  logic [BEAT_W-1:0] n_cnt;

  always_comb begin
    n_act  = b_act;
    n_rd   = b_rd;
    n_lin  = b_lin;
    n_base = b_base;
    n_cnt  = b_cnt + 1'b1;
    n_addr = {b_base[AW-1:BEAT_W], beat_low(b_base[BEAT_W-1:0], n_cnt, b_lin)};
    if (!adv_ld) begin
      n_act  = sel_ok;
      n_rd   = rw;
      n_lin  = burst_lin;
      n_base = addr;
      n_cnt  = '0;
      n_addr = addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act    <= 1'b0;
      b_rd     <= 1'b0;
      b_lin    <= 1'b0;
      b_base   <= '0;
      b_cnt    <= '0;
      op_valid <= 1'b0;
      op_rd    <= 1'b0;
      op_addr  <= '0;
      op_lanes <= '0;
    end else if (!hold) begin
      b_act    <= n_act;
      b_rd     <= n_rd;
      b_lin    <= n_lin;
      b_base   <= n_base;
      b_cnt    <= n_cnt;
      op_valid <= n_act;
      op_rd    <= n_rd;
      op_addr  <= n_addr;
      op_lanes <= lane_en;
    end
  end
endmodule

// File: rtl/zbt_pipe.sv
module zbt_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_st
    logic [W-1:0] src;
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_next
      assign src = g_st[g-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     r <= '0;
      else if (!hold) r <= src;
    end
  end

  assign q = g_st[STAGES-1].r;
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int AW    = 8,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             op_valid,
  input  logic             op_rd,
  input  logic [AW-1:0]    op_addr,
  input  logic [LANES-1:0] op_lanes,
  input  logic [DW-1:0]    wdata,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data
);
  localparam int LW    = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic wr_go, rd_go;
  assign wr_go = !hold && op_valid && !op_rd;
  assign rd_go = !hold && op_valid && op_rd;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    logic [LW-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_go && op_lanes[g]) mem[op_addr] <= wdata[g*LW +: LW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (rd_go) q <= mem[op_addr];
    end

    assign rd_data[g*LW +: LW] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_valid <= 1'b0;
    else if (!hold) rd_valid <= op_valid && op_rd;
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int AW    = 8,
  parameter int DW    = 36,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             adv_ld,
  input  logic             rw,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             burst_lin,
  input  logic [LANES-1:0] lane_we_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             oe_n,
  output logic [DW-1:0]    rdata,
  output logic             rdata_drive
);
  localparam int OPW = 2 + AW + LANES;

  logic             hold, sel_ok;
  logic             s1_valid, s1_rd;
  logic [AW-1:0]    s1_addr;
  logic [LANES-1:0] s1_lanes;
  logic             s2_valid, s2_rd;
  logic [AW-1:0]    s2_addr;
  logic [LANES-1:0] s2_lanes;
  logic [OPW-1:0]   s2_bus;
  logic             out_vld;

  assign hold   = clk_en_n;
  assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

  zbt_ctrl #(.AW(AW), .LANES(LANES)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .hold(hold), .adv_ld(adv_ld), .rw(rw),
    .sel_ok(sel_ok), .burst_lin(burst_lin), .addr(addr), .lane_en(~lane_we_n),
    .op_valid(s1_valid), .op_rd(s1_rd), .op_addr(s1_addr), .op_lanes(s1_lanes)
  );

  zbt_pipe #(.W(OPW), .STAGES(1)) i_pipe (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .d({s1_valid, s1_rd, s1_addr, s1_lanes}), .q(s2_bus)
  );

  assign {s2_valid, s2_rd, s2_addr, s2_lanes} = s2_bus;

  zbt_array #(.AW(AW), .DW(DW), .LANES(LANES)) i_array (
    .clk(clk), .rst_n(rst_n), .hold(hold),
    .op_valid(s2_valid), .op_rd(s2_rd), .op_addr(s2_addr), .op_lanes(s2_lanes),
    .wdata(wdata), .rd_valid(out_vld), .rd_data(rdata)
  );

  assign rdata_drive = out_vld && !oe_n;
endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          adv_ld,
  input logic          sel_a_n,
  input logic          sel_b,
  input logic          sel_c_n,
  input logic          oe_n,
  input logic [DW-1:0] rdata,
  input logic          rdata_drive,
  input logic          s1_valid,
  input logic          s1_rd,
  input logic [AW-1:0] s1_addr,
  input logic          s2_valid,
  input logic          s2_rd,
  input logic          out_vld
);
  a_r8_oe_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_drive);

  a_r6_stall_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rdata) && $stable(out_vld) && $stable(s1_valid) && $stable(s1_addr)));

  a_r1_read_reaches_out: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_valid && s2_rd) |=> out_vld);

  a_r2_write_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_valid && !s2_rd) |=> !out_vld);

  a_r7_deselect_no_op: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_ld && (sel_a_n || !sel_b || sel_c_n)) |=> !s1_valid);

  a_r4_burst_keeps_page: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv_ld && s1_valid) |=>
      (s1_valid && $stable(s1_rd) && $stable(s1_addr[AW-1:2])));
endmodule

bind zbt_sram zbt_sram_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld),
  .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .oe_n(oe_n),
  .rdata(rdata), .rdata_drive(rdata_drive), .s1_valid(s1_valid), .s1_rd(s1_rd),
  .s1_addr(s1_addr), .s2_valid(s2_valid), .s2_rd(s2_rd), .out_vld(out_vld)
);

// File: tb/test_zbt_sram.sv
`timescale 1ns/100ps
module test_zbt_sram;
  localparam int AW = 8, DW = 36, LANES = 4, LW = DW / LANES;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_en_n = 1'b0, adv_ld = 1'b0, rw = 1'b0;
  logic sel_a_n = 1'b0, sel_b = 1'b1, sel_c_n = 1'b0, burst_lin = 1'b0, oe_n = 1'b0;
  logic [LANES-1:0] lane_we_n = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdata_drive;

  always #2 clk = ~clk;

  zbt_sram #(.AW(AW), .DW(DW), .LANES(LANES)) i_zbt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_ld(adv_ld), .rw(rw),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .burst_lin(burst_lin),
    .lane_we_n(lane_we_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_drive(rdata_drive)
  );

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R1";
  bit mon_on = 1'b0;

  // Reference memory and the bench's own pipeline/burst model
  logic [DW-1:0] ref_mem [DEPTH];
  bit ph0_v, ph0_rd, ph1_v, ph1_rd;
  logic [DW-1:0] ph0_d, ph1_d;
  bit bm_act, bm_rd, bm_lin;
  logic [AW-1:0] bm_base;
  logic [1:0] bm_cnt;
  bit last_v;
  logic [DW-1:0] last_d;

  // Scoreboard queues
  bit exp_drv_q[$];
  logic [DW-1:0] exp_dat_q[$];
  string exp_tag_q[$];

  task automatic check(input string tag, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom(), $urandom()};
  endfunction

  task automatic cyc(input bit cen_n, input bit adv, input bit r, input bit a_n,
                     input bit b, input bit c_n, input logic [AW-1:0] a,
                     input logic [LANES-1:0] ln, input bit lin, input bit oe);
    bit nv, nrd;
    logic [AW-1:0] na;
    logic [DW-1:0] nd;
    logic [1:0] lo;
    @(negedge clk);
    clk_en_n = cen_n; adv_ld = adv; rw = r; sel_a_n = a_n; sel_b = b; sel_c_n = c_n;
    addr = a; lane_we_n = ln; burst_lin = lin; oe_n = oe;
    wdata = (ph1_v && !ph1_rd) ? ph1_d : rnd_word();
    if (!cen_n) begin
      if (!adv) begin
        bm_act = !a_n && b && !c_n; bm_rd = r; bm_base = a; bm_cnt = 2'd0; bm_lin = lin;
        na = a;
      end else begin
        bm_cnt = bm_cnt + 2'd1;
        lo = bm_lin ? 2'(bm_base[1:0] + bm_cnt) : (bm_base[1:0] ^ bm_cnt);
        na = {bm_base[AW-1:2], lo};
      end
      nv = bm_act; nrd = bm_rd; nd = '0;
      if (nv && nrd) nd = ref_mem[na];
      if (nv && !nrd) begin
        nd = rnd_word();
        for (int l = 0; l < LANES; l++)
          if (!ln[l]) ref_mem[na][l*LW +: LW] = nd[l*LW +: LW];
      end
      last_v = ph1_v && ph1_rd;
      if (last_v) last_d = ph1_d;
      ph1_v = ph0_v; ph1_rd = ph0_rd; ph1_d = ph0_d;
      ph0_v = nv; ph0_rd = nrd; ph0_d = nd;
    end
    exp_drv_q.push_back(last_v && !oe);
    exp_dat_q.push_back(last_d);
    exp_tag_q.push_back(cur_tag);
  endtask

  task automatic ld(input bit r, input logic [AW-1:0] a, input logic [LANES-1:0] ln = '0, input bit lin = 1'b0);
    cyc(1'b0, 1'b0, r, 1'b0, 1'b1, 1'b0, a, ln, lin, 1'b0);
  endtask
  task automatic adv(input bit r = 1'b0);
    cyc(1'b0, 1'b1, r, 1'b0, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask
  task automatic stall();
    cyc(1'b1, 1'b0, $urandom_range(0, 1), 1'b0, 1'b1, 1'b0, AW'($urandom()), '0, 1'b0, 1'b0);
  endtask
  task automatic flush();
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0, 1'b0, 1'b0);
  endtask

  // Monitor: compares the ports against each queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on && exp_drv_q.size() > 0) begin
        bit ed;
        logic [DW-1:0] edat;
        string t;
        ed = exp_drv_q.pop_front(); edat = exp_dat_q.pop_front(); t = exp_tag_q.pop_front();
        check({t, " drive"}, rdata_drive == ed, DW'(rdata_drive), DW'(ed));
        if (ed) check({t, " data"}, rdata == edat, rdata, edat);
      end
    end
  end

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    ph0_v = 0; ph1_v = 0; ph0_rd = 0; ph1_rd = 0; ph0_d = '0; ph1_d = '0;
    bm_act = 0; bm_rd = 0; bm_lin = 0; bm_base = '0; bm_cnt = '0; last_v = 0; last_d = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state at the ports
    @(negedge clk);
    check("R9 drive after reset", rdata_drive == 1'b0, DW'(rdata_drive), '0);
    check("R9 data after reset", rdata == '0, rdata, '0);
    mon_on = 1'b1;

    // R2: fill every word with full-lane writes at full rate
    cur_tag = "R2";
    for (int i = 0; i < DEPTH; i++) ld(1'b0, AW'(i));
    // R1: read them all back
    cur_tag = "R1";
    for (int i = 0; i < DEPTH; i++) ld(1'b1, AW'(i));
    flush();

    // R3: alternating write/read on the same and on different addresses
    cur_tag = "R3";
    for (int i = 0; i < 40; i++) begin
      ld(1'b0, AW'(i * 3));
      ld(1'b1, AW'(i * 3));
      ld(1'b1, AW'(i * 3 + 1));
      ld(1'b0, AW'(i * 3 + 1));
    end
    flush();

    // R2: partial-lane writes, then reads
    cur_tag = "R2";
    for (int i = 0; i < 16; i++) ld(1'b0, AW'(40 + i), LANES'(i));
    for (int i = 0; i < 16; i++) ld(1'b1, AW'(40 + i));
    flush();

    // R4/R5: bursts from every start offset in both orders; rw flips on advances
    for (int lin = 0; lin < 2; lin++)
      for (int s = 0; s < 4; s++) begin
        cur_tag = (lin != 0) ? "R5" : "R4";
        ld(1'b0, AW'(8'h80 + s), '0, lin[0]);
        adv(1'b1); adv(1'b1); adv(1'b0); adv(1'b1);
        ld(1'b1, AW'(8'h80 + s), '0, lin[0]);
        adv(1'b0); adv(1'b0); adv(1'b1);
        ld(1'b1, AW'(8'h80 + ((s + 1) % 4)), '0, lin[0] ^ 1'b1);
        adv(); adv(); adv();
      end
    flush();

    // R6: stalls inside a read/write stream and inside a burst
    cur_tag = "R6";
    ld(1'b0, 8'h10); stall(); ld(1'b1, 8'h10); stall(); stall(); ld(1'b0, 8'h11);
    ld(1'b1, 8'h11); stall(); ld(1'b0, 8'h92, '0, 1'b1); adv(); stall(); stall(); adv(); adv();
    ld(1'b1, 8'h92, '0, 1'b0); stall(); adv(); adv(); stall(); adv();
    for (int i = 0; i < 4; i++) stall();
    flush();

    // R7: each select deasserted, writes under deselect, advance after deselect
    cur_tag = "R7";
    ld(1'b1, 8'h20);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h20, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h21, '0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h22, '0, 1'b0, 1'b0);
    adv(); adv();
    ld(1'b1, 8'h20); ld(1'b1, 8'h21); ld(1'b1, 8'h22);
    flush();

    // R8: output enable, clocked and mid-cycle
    cur_tag = "R8";
    ld(1'b1, 8'h30);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h31, '0, 1'b0, 1'b1);
    ld(1'b1, 8'h32); ld(1'b1, 8'h33);
    stall(); stall();
    @(negedge clk); #0.5;
    // R8: rdata_drive follows oe_n between edges
    oe_n = 1'b1; #0.5;
    check("R8 async off", rdata_drive == 1'b0, DW'(rdata_drive), '0);
    oe_n = 1'b0; #0.5;
    check("R8 async on", rdata_drive == 1'b1, DW'(rdata_drive), DW'(1));
    exp_drv_q.push_back(last_v); exp_dat_q.push_back(last_d); exp_tag_q.push_back("R8");
    flush();

    // R1: random mix of everything
    cur_tag = "R1";
    for (int i = 0; i < 3000; i++) begin
      bit dsel;
      dsel = ($urandom_range(0, 9) == 0);
      cyc($urandom_range(0, 9) == 0, $urandom_range(0, 9) < 4, $urandom_range(0, 1),
          dsel && $urandom_range(0, 1) != 0, !(dsel && $urandom_range(0, 1) != 0), 1'b0,
          AW'($urandom()), LANES'($urandom()), $urandom_range(0, 1), $urandom_range(0, 9) == 0);
    end
    flush();
    cur_tag = "R1";
    for (int i = 0; i < DEPTH; i++) ld(1'b1, AW'(i));
    flush();
    @(negedge clk); @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule